// File: doc/BRIEF.md
# SD SPI Block-Read Response Token Detector

This block watches the byte stream received from an SD card running in SPI mode once a single- or multi-block read command has been sent. A one-cycle start pulse marks that the command went out. From then on every received byte (qualified by a valid strobe) is classified. The command response (R1) comes first: all-ones filler is skipped, and the first byte whose top bit is clear is taken as the response. If the response reports no error, the block goes on to look for the token that opens the data phase.

Detection works on whole bytes, not on a sliding bit window. After the response, idle 0xFF bytes are skipped. The first other byte decides the outcome:
- a data start token, so a payload capture path can begin;
- an error token, whose error bits are reported;
- anything else, reported as a protocol error.

Both waits are bounded by a byte-count limit that raises a timeout. After any final outcome the detector stays inert until the next start pulse, so payload bytes are never taken for tokens.

Top module: `blkrd_token_det`

## Requirements
- R1: While and right after reset, all pulse outputs (`r1_valid_o`, `data_start_o`, `err_valid_o`, `proto_err_o`, `timeout_o`) are 0, and `r1_o` and `err_code_o` are 0.
- R2: After a start pulse, accepted bytes with bit 7 set are filler. The first accepted byte with bit 7 clear is the response. In the cycle after that byte is accepted, `r1_valid_o` pulses for one cycle and `r1_o` holds the byte until the next response.
- R3: A response with any of bits 6..0 set ends the transaction. Later bytes, including 0xFE, produce no outcome pulse until the next start pulse.
- R4: After a response of 0x00, 0xFF bytes are skipped. A 0xFE byte pulses `data_start_o` in the following cycle.
- R5: In the token wait, a byte with bits 7..5 equal to 000 and bits 4..0 nonzero pulses `err_valid_o` in the following cycle, with `err_code_o` equal to bits 4..0.
- R6: In the token wait, any byte other than 0xFF, 0xFE or a valid error token pulses `proto_err_o` in the following cycle. This includes 0x00 and any byte with nonzero bits 7..5.
- R7: WAIT_LIMIT consecutive filler bytes in the response wait or in the token wait pulse `timeout_o` on the cycle after the last of them, and the detector goes inert. WAIT_LIMIT-1 filler bytes do not. The count restarts when the response arrives.
- R8: After `data_start_o`, `err_valid_o`, `proto_err_o` or `timeout_o`, no byte produces any output pulse until the next start pulse.
- R9: A start pulse restarts the response wait from any state and clears the filler count. A byte presented in the same cycle as a start pulse is ignored.
- R10: Cycles with `rx_valid_i` low change nothing. At most one of the five pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: a block read command was issued |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| r1_valid_o | output | 1 | Pulse: response byte captured |
| r1_o | output | 8 | Last captured response byte |
| data_start_o | output | 1 | Pulse: data start token seen |
| err_valid_o | output | 1 | Pulse: error token seen |
| err_code_o | output | 5 | Error bits of the last error token |
| proto_err_o | output | 1 | Pulse: unexpected byte in token wait |
| timeout_o | output | 1 | Pulse: filler limit reached |

## Verification
The bench sweeps every 7-bit response value, preceded by a bit-7-set filler byte. A design that searched for a token after a flagged response would raise a false data start. The bench also sweeps all 256 bytes in the token position. A design that matched bit patterns loosely would confuse 0x00 or 0x20..0xFD with error tokens, or report a wrong error code. The timeout is probed one byte short of the limit and at the limit, in both waits, and across the response boundary. This catches off-by-one limits and counters that are not cleared when the response arrives. After each outcome, further 0xFE and 0x00 bytes are sent to catch a detector that keeps parsing payload. A start pulse that arrives with a byte in the same cycle checks that the byte is dropped.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 5;
    localparam logic [BYTE_W-1:0] FILL_BYTE   = 8'hFF;
    localparam logic [BYTE_W-1:0] START_TOKEN = 8'hFE;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT_RESP,
        PH_WAIT_TOKEN
    } phase_e;

    typedef enum logic [1:0] {
        TK_FILL,
        TK_START,
        TK_ERROR,
        TK_BAD
    } tok_kind_e;

    typedef struct packed {
        logic             resp_ok;
        logic             resp_flags;
        tok_kind_e        kind;
        logic [CODE_W-1:0] code;
    } byte_class_t;

    function automatic tok_kind_e kind_of(input logic [BYTE_W-1:0] b);
        if (b == FILL_BYTE)
            return TK_FILL;
        else if (b == START_TOKEN)
            return TK_START;
        else if (b[BYTE_W-1:CODE_W] == '0 && b[CODE_W-1:0] != '0)
            return TK_ERROR;
        else
            return TK_BAD;
    endfunction

endpackage

// File: rtl/blkrd_classify.sv
module blkrd_classify
    import blkrd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output byte_class_t       cls_o
);
    always_comb begin
        cls_o.resp_ok    = ~byte_i[BYTE_W-1];
        cls_o.resp_flags = |byte_i[BYTE_W-2:0];
        cls_o.kind       = kind_of(byte_i);
        cls_o.code       = byte_i[CODE_W-1:0];
    end
endmodule

// File: rtl/blkrd_waitcnt.sv
module blkrd_waitcnt #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = inc_i && (cnt_q == LAST);
endmodule

// File: rtl/blkrd_token_det.sv
module blkrd_token_det
    import blkrd_pkg::*;
#(
    parameter int WAIT_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_byte_i,
    output logic        r1_valid_o,
    output logic [7:0]  r1_o,
    output logic        data_start_o,
    output logic        err_valid_o,
    output logic [4:0]  err_code_o,
    output logic        proto_err_o,
    output logic        timeout_o
);
    phase_e      phase_q;
    byte_class_t cls;
    logic        take;
    logic        cnt_clr;
    logic        cnt_inc;
    logic        cnt_hit;

    blkrd_classify u_cls (
        .byte_i (rx_byte_i),
        .cls_o  (cls)
    );

    assign take    = rx_valid_i && !start_i;
    assign cnt_clr = start_i || (take && phase_q == PH_WAIT_RESP && cls.resp_ok);
    assign cnt_inc = take && ((phase_q == PH_WAIT_RESP && !cls.resp_ok) ||
                              (phase_q == PH_WAIT_TOKEN && cls.kind == TK_FILL));

    blkrd_waitcnt #(.LIMIT(WAIT_LIMIT)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .hit_o (cnt_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            r1_valid_o   <= 1'b0;
            r1_o         <= '0;
            data_start_o <= 1'b0;
            err_valid_o  <= 1'b0;
            err_code_o   <= '0;
            proto_err_o  <= 1'b0;
            timeout_o    <= 1'b0;
        end else begin
            r1_valid_o   <= 1'b0;
            data_start_o <= 1'b0;
            err_valid_o  <= 1'b0;
            proto_err_o  <= 1'b0;
            timeout_o    <= 1'b0;
            if (start_i) begin
                phase_q <= PH_WAIT_RESP;
            end else if (rx_valid_i) begin
                case (phase_q)
                    PH_WAIT_RESP: begin
                        if (cls.resp_ok) begin
                            r1_valid_o <= 1'b1;
                            r1_o       <= rx_byte_i;
                            phase_q    <= cls.resp_flags ? PH_IDLE : PH_WAIT_TOKEN;
                        end else if (cnt_hit) begin
                            timeout_o <= 1'b1;
                            phase_q   <= PH_IDLE;
                        end
                    end
                    PH_WAIT_TOKEN: begin
                        case (cls.kind)
                            TK_FILL: begin
                                if (cnt_hit) begin
                                    timeout_o <= 1'b1;
                                    phase_q   <= PH_IDLE;
                                end
                            end
                            TK_START: begin
                                data_start_o <= 1'b1;
                                phase_q      <= PH_IDLE;
                            end
                            TK_ERROR: begin
                                err_valid_o <= 1'b1;
                                err_code_o  <= cls.code;
                                phase_q     <= PH_IDLE;
                            end
                            default: begin
                                proto_err_o <= 1'b1;
                                phase_q     <= PH_IDLE;
                            end
                        endcase
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/blkrd_token_det_chk.sv
module blkrd_token_det_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       rx_valid_i,
    input logic [7:0] rx_byte_i,
    input logic       r1_valid_o,
    input logic [7:0] r1_o,
    input logic       data_start_o,
    input logic       err_valid_o,
    input logic [4:0] err_code_o,
    input logic       proto_err_o,
    input logic       timeout_o
);
    logic any_pulse;
    assign any_pulse = r1_valid_o | data_start_o | err_valid_o | proto_err_o | timeout_o;

    // R10: outcomes never coincide
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({r1_valid_o, data_start_o, err_valid_o, proto_err_o, timeout_o}));

    // R10, R9: every pulse follows an accepted byte
    p_pulse_needs_byte_r10: assert property (@(posedge clk) disable iff (rst)
        any_pulse |-> $past(rx_valid_i && !start_i));

    // R2: the captured response is the accepted byte, with its top bit clear
    p_resp_value_r2: assert property (@(posedge clk) disable iff (rst)
        r1_valid_o |-> (!r1_o[7] && r1_o == $past(rx_byte_i)));

    // R4: data start follows a 0xFE byte
    p_start_token_r4: assert property (@(posedge clk) disable iff (rst)
        data_start_o |-> $past(rx_byte_i) == 8'hFE);

    // R5: the error code is the low bits of an error token
    p_err_code_r5: assert property (@(posedge clk) disable iff (rst)
        err_valid_o |-> (err_code_o != 5'd0 && err_code_o == $past(rx_byte_i[4:0])
                         && $past(rx_byte_i[7:5]) == 3'b000));

    // R7: a timeout is triggered by a filler byte
    p_timeout_on_fill_r7: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(rx_byte_i[7]));

    // R2: the response register holds between captures
    p_resp_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !r1_valid_o |=> (r1_valid_o || $stable(r1_o)));
endmodule

bind blkrd_token_det blkrd_token_det_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .rx_valid_i   (rx_valid_i),
    .rx_byte_i    (rx_byte_i),
    .r1_valid_o   (r1_valid_o),
    .r1_o         (r1_o),
    .data_start_o (data_start_o),
    .err_valid_o  (err_valid_o),
    .err_code_o   (err_code_o),
    .proto_err_o  (proto_err_o),
    .timeout_o    (timeout_o)
);

// File: tb/sim_blkrd_token_det.sv
`timescale 1ns/1ps
module sim_blkrd_token_det;
    localparam int LIM = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = 8'hFF;
    logic       r1_valid_o, data_start_o, err_valid_o, proto_err_o, timeout_o;
    logic [7:0] r1_o;
    logic [4:0] err_code_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    blkrd_token_det #(.WAIT_LIMIT(LIM)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .r1_valid_o(r1_valid_o), .r1_o(r1_o),
        .data_start_o(data_start_o), .err_valid_o(err_valid_o),
        .err_code_o(err_code_o), .proto_err_o(proto_err_o),
        .timeout_o(timeout_o)
    );

    // pulse vector order: {r1, data_start, err, proto, timeout}
    localparam logic [4:0] P_NONE = 5'b00000;
    localparam logic [4:0] P_R1   = 5'b10000;
    localparam logic [4:0] P_DS   = 5'b01000;
    localparam logic [4:0] P_ERR  = 5'b00100;
    localparam logic [4:0] P_BAD  = 5'b00010;
    localparam logic [4:0] P_TMO  = 5'b00001;

    function automatic logic [4:0] pulses();
        return {r1_valid_o, data_start_o, err_valid_o, proto_err_o, timeout_o};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_p(input string req, input logic [4:0] exp);
        chk(pulses() == exp, req, int'(pulses()), int'(exp));
    endtask

    // called at a negedge; returns at the next negedge with outputs settled
    task automatic send(input logic [7:0] b);
        rx_valid_i = 1'b1;
        rx_byte_i  = b;
        @(posedge clk);
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_byte_i  = 8'hFF;
    endtask

    task automatic go();
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    function automatic logic [4:0] tok_expect(input logic [7:0] v);
        if (v == 8'hFF) return P_NONE;
        if (v == 8'hFE) return P_DS;
        if (v < 8'h20 && v != 8'h00) return P_ERR;
        return P_BAD;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_p("R1 pulses in reset", P_NONE);
        chk(r1_o == 8'h00 && err_code_o == 5'd0, "R1 held values", {r1_o, 3'b0, err_code_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_p("R1 pulses after reset", P_NONE);

        // R8: before any start, bytes are ignored
        send(8'h00);
        chk_p("R8 no start, 0x00", P_NONE);
        send(8'hFE);
        chk_p("R8 no start, 0xFE", P_NONE);

        // R2, R3: sweep all response values
        for (int r = 0; r < 128; r++) begin
            go();
            send(8'h80 | 8'(r));
            chk_p("R2 bit7 filler", P_NONE);
            send(8'(r));
            chk_p("R2 response pulse", P_R1);
            chk(r1_o == 8'(r), "R2 response value", r1_o, r);
            send(8'hFE);
            if (r == 0) chk_p("R4 token after clean response", P_DS);
            else        chk_p("R3 no token search after flagged response", P_NONE);
            chk(r1_o == 8'(r), "R2 response held", r1_o, r);
        end

        // R4, R5, R6, R8: sweep all token bytes
        for (int v = 0; v < 256; v++) begin
            go();
            send(8'hFF);
            send(8'h00);
            chk_p("R4 clean response", P_R1);
            send(8'(v));
            if (tok_expect(8'(v)) == P_ERR) begin
                chk_p("R5 error token pulse", P_ERR);
                chk(err_code_o == 5'(v), "R5 error code", err_code_o, v & 31);
            end else if (tok_expect(8'(v)) == P_BAD) begin
                chk_p("R6 protocol error", P_BAD);
            end else if (v == 255) begin
                chk_p("R4 filler skipped in token wait", P_NONE);
                send(8'hFE);
                chk_p("R4 start after filler", P_DS);
            end else begin
                chk_p("R4 start token", P_DS);
            end
            send(8'hFE);
            chk_p("R8 inert after outcome (0xFE)", P_NONE);
            send(8'h00);
            chk_p("R8 inert after outcome (0x00)", P_NONE);
        end

        // R7: timeout in response wait
        go();
        for (int i = 0; i < LIM - 1; i++) send(8'hFF);
        chk_p("R7 no timeout at limit-1 (response)", P_NONE);
        send(8'hFF);
        chk_p("R7 timeout at limit (response)", P_TMO);
        send(8'h00);
        chk_p("R8 inert after timeout", P_NONE);

        // R7: count restarts at response; timeout in token wait
        go();
        for (int i = 0; i < LIM - 1; i++) send(8'hFF);
        send(8'h00);
        chk_p("R7 response just before limit", P_R1);
        for (int i = 0; i < LIM - 1; i++) send(8'hFF);
        chk_p("R7 no timeout at limit-1 (token)", P_NONE);
        send(8'hFF);
        chk_p("R7 timeout at limit (token)", P_TMO);

        go();
        send(8'h00);
        for (int i = 0; i < LIM - 1; i++) send(8'hFF);
        send(8'hFE);
        chk_p("R7 token at limit-1 fillers", P_DS);

        // R9: restart mid token wait clears count
        go();
        send(8'h00);
        for (int i = 0; i < LIM - 1; i++) send(8'hFF);
        go();
        send(8'hFF);
        chk_p("R9 restart clears count", P_NONE);
        send(8'h00);
        chk_p("R9 response after restart", P_R1);

        // R9: byte in the start cycle is ignored
        start_i = 1'b1;
        rx_valid_i = 1'b1;
        rx_byte_i = 8'h05;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        rx_valid_i = 1'b0;
        rx_byte_i = 8'hFF;
        chk_p("R9 byte with start ignored", P_NONE);
        chk(r1_o == 8'h00, "R9 response not taken with start", r1_o, 0);

        // R10: valid low changes nothing
        rx_byte_i = 8'h07;
        repeat (4) @(negedge clk);
        chk_p("R10 valid low ignored", P_NONE);
        chk(r1_o == 8'h00, "R10 response unchanged", r1_o, 0);
        send(8'h07);
        chk_p("R10 next valid byte is response", P_R1);
        chk(r1_o == 8'h07, "R10 response value", r1_o, 7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule